// File: doc/BRIEF.md
# Keyed-Switch Sampling ADC Register Controller

This block is the bus-facing front end of a multiplexed sampling converter. Software reaches it through a plain register port with an address, read and write strobes, write data and registered read data. The analog side is a stub that always presents its current digitized value on `sample_in`. The block also drives the routing pattern that selects the converter's input. A read of the result register is itself the start command. The block then counts out the conversion time, and any input settling time still due after a routing change. When both have run out it captures the sample and raises a ready flag in the result word.

The input-routing register is guarded by a one-shot key. Software first writes the key value to the lock register. The very next bus access must be the routing write, or the guard closes again. A single select input picks between a fast clock-divider setting and a slow one. That choice sets both the conversion length and the settling length, each a parameter counted in clock cycles.

Top module: `adc_keyed_ctrl`

## Requirements
- R1: The result register is at offset 0x08, the routing register at 0x18 and the lock register at 0x20. A read of the routing register returns the pattern in bits 11:0 with zeros above it. A read of the lock register, or of any other offset, returns zero.
- R2: `bus_rdata` is registered. It changes on the clock edge that samples `bus_rd` and holds its value until the next read. A read of the result register returns the word as it stood before that read, so the content is stale with respect to the conversion the read starts.
- R3: Every read of the result register starts a conversion and clears the ready flag on the same edge.
- R4: The result word carries the ready flag in bit 31, zeros in bits 30:16, and the captured sample in bits 15:0 as a signed 16-bit value with a nominal span of -25000 to +25000. If no settling time is pending, the sample is captured and the flag set on the (N+1)th clock edge after the start edge, where N is the conversion length.
- R5: A write to the routing register while the guard is closed is ignored, and `route_sel` keeps its value.
- R6: Writing exactly 0x000000AA to the lock register opens the guard. A routing write that immediately follows it loads `bus_wdata[11:0]` into the routing register and onto `route_sel`. The defined patterns are 0x608, 0x680, 0x640, 0x620, 0x610, 0x601, 0x602 and 0x604.
- R7: Once the guard is open, any access other than another key write closes it again. This covers a read of any offset, a write elsewhere, a lock write with a wrong value, and the accepted routing write itself.
- R8: A start that arrives while a conversion is running restarts the full conversion count. No result is captured until N+1 edges after the last start.
- R9: After reset the guard is closed, the ready flag is clear, the routing pattern and captured sample are zero, and `bus_rdata` is zero.
- R10: Each accepted routing write loads a settling count. A conversion whose count has run out still does not capture while settling time remains.
- R11: `div_sel` = 0 selects the fast conversion and settling lengths, and 1 selects the slow ones. The value is sampled at the start edge for the conversion length and at the routing write for the settling length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sample_in | input | 16 | Digitized value from the analog stub |
| div_sel | input | 1 | 0 = fast divider setting, 1 = slow setting |
| route_sel | output | 12 | Current input-routing pattern |

## Verification
Read data is due one edge after the read strobe, and a routing change shows on `route_sel` one edge after the accepted write. The ready flag can first appear in a read made N+2 edges after a start, or one edge after any settling count has drained if that comes later. The bench keeps a behavioural model stepped on the same rising edge and compares `bus_rdata` and `route_sel` on every falling edge. Its directed reads are placed a few cycles before and after each due edge, so that an off-by-a-few timer, a missing restart or an ignored settling count each change the observed flag.

// File: rtl/adc_kc_pkg.sv
package adc_kc_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int ROUTE_W = 12;
    localparam int SMP_W   = 16;
    localparam int FLAG_BIT = 31;

    localparam logic [ADDR_W-1:0] OFF_RESULT = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_ROUTE  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_GUARD  = 8'h20;
    localparam logic [DATA_W-1:0] GUARD_KEY  = 32'h0000_00AA;

    typedef enum logic {
        DIV_FAST = 1'b0,
        DIV_SLOW = 1'b1
    } div_mode_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic start_conv;
        logic key_write;
        logic route_write;
        logic any_access;
    } bus_evt_t;

    function automatic logic [DATA_W-1:0] pack_result(input logic ready,
                                                      input logic [SMP_W-1:0] smp);
        logic [DATA_W-1:0] w;
        w = '0;
        w[FLAG_BIT]    = ready;
        w[SMP_W-1:0]   = smp;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_route(input logic [ROUTE_W-1:0] r);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ROUTE_W-1:0] = r;
        return w;
    endfunction

endpackage

// File: rtl/adc_kc_decode.sv
module adc_kc_decode
    import adc_kc_pkg::*;
(
    input  bus_req_t req,
    output bus_evt_t evt
);
    always_comb begin
        evt.start_conv  = req.rd && (req.addr == OFF_RESULT);
        evt.key_write   = req.wr && (req.addr == OFF_GUARD) && (req.wdata == GUARD_KEY);
        evt.route_write = req.wr && (req.addr == OFF_ROUTE);
        evt.any_access  = req.rd || req.wr;
    end
endmodule

// File: rtl/adc_kc_keygate.sv
module adc_kc_keygate
    import adc_kc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_evt_t           evt,
    input  logic [ROUTE_W-1:0] new_route,
    output logic [ROUTE_W-1:0] route,
    output logic               route_taken
);
    logic is_open;

    assign route_taken = evt.route_write && is_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            route   <= '0;
        end else begin
            if (evt.key_write)
                is_open <= 1'b1;
            else if (evt.any_access)
                is_open <= 1'b0;
            if (route_taken)
                route <= new_route;
        end
    end

    // R5: a routing write with the guard closed leaves the pattern alone
    a_r5_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (evt.route_write && !is_open) |=> $stable(route));

    // R6: the pattern only moves after an open-guard routing write
    a_r6_change_needs_key: assert property (@(posedge clk) disable iff (rst)
        !$stable(route) |-> ($past(is_open) && $past(evt.route_write)));

    // R7: any non-key access closes the guard
    a_r7_one_shot: assert property (@(posedge clk) disable iff (rst)
        (evt.any_access && !evt.key_write) |=> !is_open);

endmodule

// File: rtl/adc_kc_engine.sv
module adc_kc_engine
    import adc_kc_pkg::*;
#(
    parameter int CONV_FAST_CYC   = 13334,
    parameter int CONV_SLOW_CYC   = 54055,
    parameter int SETTLE_FAST_CYC = 25000,
    parameter int SETTLE_SLOW_CYC = 100000
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_conv,
    input  logic             settle_load,
    input  div_mode_e        div_mode,
    input  logic [SMP_W-1:0] sample_in,
    output logic             ready,
    output logic [SMP_W-1:0] result
);
    localparam int CONV_MAX   = (CONV_FAST_CYC > CONV_SLOW_CYC) ? CONV_FAST_CYC : CONV_SLOW_CYC;
    localparam int SETTLE_MAX = (SETTLE_FAST_CYC > SETTLE_SLOW_CYC) ? SETTLE_FAST_CYC : SETTLE_SLOW_CYC;
    localparam int CW = $clog2(CONV_MAX + 1);
    localparam int SW = $clog2(SETTLE_MAX + 1);

    logic [CW-1:0] conv_cnt;
    logic [SW-1:0] settle_cnt;
    logic          busy;
    logic [CW-1:0] conv_len;
    logic [SW-1:0] settle_len;

    always_comb begin
        conv_len   = (div_mode == DIV_SLOW) ? CW'(CONV_SLOW_CYC)   : CW'(CONV_FAST_CYC);
        settle_len = (div_mode == DIV_SLOW) ? SW'(SETTLE_SLOW_CYC) : SW'(SETTLE_FAST_CYC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_cnt <= '0;
        end else if (settle_load) begin
            settle_cnt <= settle_len;
        end else if (settle_cnt != '0) begin
            settle_cnt <= settle_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            ready    <= 1'b0;
            result   <= '0;
            conv_cnt <= '0;
        end else if (start_conv) begin
            busy     <= 1'b1;
            ready    <= 1'b0;
            conv_cnt <= conv_len;
        end else if (busy) begin
            if (conv_cnt != '0) begin
                conv_cnt <= conv_cnt - 1'b1;
            end else if (settle_cnt == '0) begin
                result <= sample_in;
                ready  <= 1'b1;
                busy   <= 1'b0;
            end
        end
    end

    // R3: a start always leaves the flag clear on the next cycle
    a_r3_start_clears_ready: assert property (@(posedge clk) disable iff (rst)
        start_conv |=> !ready);

    // R10: capture never happens with settling time outstanding
    a_r10_settle_gates_capture: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(settle_cnt) == '0 && $past(conv_cnt) == '0));

endmodule

// File: rtl/adc_keyed_ctrl.sv
module adc_keyed_ctrl
    import adc_kc_pkg::*;
#(
    parameter int CONV_FAST_CYC   = 13334,
    parameter int CONV_SLOW_CYC   = 54055,
    parameter int SETTLE_FAST_CYC = 25000,
    parameter int SETTLE_SLOW_CYC = 100000
)(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [15:0] sample_in,
    input  logic        div_sel,
    output logic [11:0] route_sel
);
    bus_req_t         req;
    bus_evt_t         evt;
    logic             route_taken;
    logic             ready;
    logic [SMP_W-1:0] result;

    always_comb begin
        req.rd    = bus_rd;
        req.wr    = bus_wr;
        req.addr  = bus_addr;
        req.wdata = bus_wdata;
    end

    adc_kc_decode u_decode (
        .req (req),
        .evt (evt)
    );

    adc_kc_keygate u_keygate (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .new_route   (bus_wdata[ROUTE_W-1:0]),
        .route       (route_sel),
        .route_taken (route_taken)
    );

    adc_kc_engine #(
        .CONV_FAST_CYC   (CONV_FAST_CYC),
        .CONV_SLOW_CYC   (CONV_SLOW_CYC),
        .SETTLE_FAST_CYC (SETTLE_FAST_CYC),
        .SETTLE_SLOW_CYC (SETTLE_SLOW_CYC)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .start_conv  (evt.start_conv),
        .settle_load (route_taken),
        .div_mode    (div_mode_e'(div_sel)),
        .sample_in   (sample_in),
        .ready       (ready),
        .result      (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (bus_addr)
                OFF_RESULT: bus_rdata <= pack_result(ready, result);
                OFF_ROUTE:  bus_rdata <= pack_route(route_sel);
                default:    bus_rdata <= '0;
            endcase
        end
    end

    // R1: unmapped and lock offsets read as zero
    a_r1_blank_offsets: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr != OFF_RESULT && bus_addr != OFF_ROUTE) |=> (bus_rdata == '0));

    // R4: bits between flag and sample are always zero in a result read
    a_r4_result_format: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_RESULT) |=> (bus_rdata[30:16] == '0));

endmodule

// File: tb/tb_adc_keyed_ctrl.sv
module tb_adc_keyed_ctrl;
    localparam int CF = 6;
    localparam int CS = 20;
    localparam int SF = 15;
    localparam int SS = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] sample_in = '0;
    logic        div_sel = 1'b0;
    logic [11:0] route_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    adc_keyed_ctrl #(
        .CONV_FAST_CYC(CF), .CONV_SLOW_CYC(CS),
        .SETTLE_FAST_CYC(SF), .SETTLE_SLOW_CYC(SS)
    ) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sample_in(sample_in), .div_sel(div_sel), .route_sel(route_sel)
    );

    // behavioural reference
    bit          m_open, m_ready, m_busy;
    logic [11:0] m_route;
    logic [15:0] m_res;
    logic [31:0] m_rdata;
    int          m_conv, m_settle;

    always @(posedge clk) begin
        if (rst) begin
            m_open = 0; m_ready = 0; m_busy = 0; m_route = '0; m_res = '0;
            m_rdata = '0; m_conv = 0; m_settle = 0;
        end else begin
            bit old_open, old_ready, taken;
            int old_settle;
            old_open = m_open; old_ready = m_ready; old_settle = m_settle;
            if (bus_rd) begin
                if (bus_addr == 8'h08)      m_rdata = {old_ready, 15'd0, m_res};
                else if (bus_addr == 8'h18) m_rdata = {20'd0, m_route};
                else                        m_rdata = '0;
            end
            if (bus_wr && bus_addr == 8'h20 && bus_wdata == 32'hAA) m_open = 1;
            else if (bus_rd || bus_wr) m_open = 0;
            taken = bus_wr && bus_addr == 8'h18 && old_open;
            if (taken) begin
                m_route  = bus_wdata[11:0];
                m_settle = div_sel ? SS : SF;
            end else if (old_settle > 0) m_settle = old_settle - 1;
            if (bus_rd && bus_addr == 8'h08) begin
                m_busy = 1; m_ready = 0; m_conv = div_sel ? CS : CF;
            end else if (m_busy) begin
                if (m_conv > 0) m_conv = m_conv - 1;
                else if (old_settle == 0) begin
                    m_res = sample_in; m_ready = 1; m_busy = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            n_cmp++;
            if (bus_rdata !== m_rdata) begin
                n_bad++;
                $display("FAIL R2 read data: actual %h expected %h", bus_rdata, m_rdata);
            end
            n_cmp++;
            if (route_sel !== m_route) begin
                n_bad++;
                $display("FAIL R6 route: actual %h expected %h", route_sel, m_route);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 rdata after reset", bus_rdata, 32'h0);
        chk("R9 route after reset", {20'd0, route_sel}, 32'h0);
        rd(8'h18);
        chk("R1 route read at reset", bus_rdata, 32'h0);

        sample_in = 16'h1234;
        rd(8'h08);
        chk("R2 first result read is stale", bus_rdata, 32'h0);
        idle(CF + 3);
        rd(8'h08);
        chk("R4 ready word", bus_rdata, 32'h8000_1234);
        rd(8'h08);
        chk("R3 flag cleared by previous read", bus_rdata, 32'h0000_1234);

        wr(8'h18, 32'h608);
        chk("R5 locked write", {20'd0, route_sel}, 32'h0);
        wr(8'h20, 32'hAA);
        wr(8'h18, 32'h680);
        chk("R6 keyed write", {20'd0, route_sel}, 32'h680);
        rd(8'h18);
        chk("R1 route readback", bus_rdata, 32'h680);
        wr(8'h18, 32'h640);
        chk("R7 guard closed after accepted write", {20'd0, route_sel}, 32'h680);
        wr(8'h20, 32'hAA);
        rd(8'h20);
        chk("R1 lock reads zero", bus_rdata, 32'h0);
        wr(8'h18, 32'h620);
        chk("R7 read between key and write", {20'd0, route_sel}, 32'h680);
        wr(8'h20, 32'h55);
        wr(8'h18, 32'h610);
        chk("R7 wrong key", {20'd0, route_sel}, 32'h680);
        rd(8'h40);
        chk("R1 unmapped read", bus_rdata, 32'h0);

        // fast settling after a routing change
        wr(8'h20, 32'hAA);
        wr(8'h18, 32'h601);
        sample_in = 16'hA0B0;
        rd(8'h08);
        idle(CF + 3);
        rd(8'h08);
        chk("R10 not ready while settling", {31'd0, bus_rdata[31]}, 32'h0);
        idle(CF + 3);
        rd(8'h08);
        chk("R10 ready after settling", bus_rdata, 32'h8000_A0B0);

        // restart while busy
        sample_in = 16'h0F0F;
        idle(CF + 3);
        rd(8'h08);
        idle(CF - 2);
        rd(8'h08);
        idle(CF - 2);
        rd(8'h08);
        chk("R8 restart delays ready", {31'd0, bus_rdata[31]}, 32'h0);
        idle(CF + 3);
        rd(8'h08);
        chk("R8 ready after full count", bus_rdata, 32'h8000_0F0F);

        // slow divider
        div_sel = 1'b1;
        sample_in = 16'h6000;
        idle(CS + 3);
        rd(8'h08);
        idle(CF + 3);
        rd(8'h08);
        chk("R11 slow count not done at fast length", {31'd0, bus_rdata[31]}, 32'h0);
        idle(CS + 3);
        rd(8'h08);
        chk("R11 slow count done", bus_rdata, 32'h8000_6000);

        wr(8'h20, 32'hAA);
        wr(8'h18, 32'h604);
        chk("R6 second keyed write", {20'd0, route_sel}, 32'h604);
        sample_in = 16'h9E58;
        rd(8'h08);
        idle(CS + 3);
        rd(8'h08);
        chk("R10 slow settling blocks", {31'd0, bus_rdata[31]}, 32'h0);
        idle(SS + 5);
        rd(8'h08);
        chk("R10 slow settling done", bus_rdata, 32'h8000_9E58);

        idle(2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule